// File: doc/BRIEF.md
# Accumulator Immediate Arithmetic Unit

This block holds two 40-bit signed accumulators, A and B, and applies one operation per clock to whichever of them is selected. Each accumulator has three parts: bits 39..32 (guard byte), bits 31..16 (middle word) and bits 15..0 (low word). Immediates that take part in arithmetic are placed in the middle word before the operation. The block also takes two 32-bit source operands, X and Y, which feed the carry arithmetic, the magnitude comparison and accumulator loading.

The operation set covers several groups:
- immediate add and compare;
- add and subtract with carry from a 32-bit source;
- negate with carry;
- magnitude comparison against a 16-bit source half;
- logical and arithmetic shifts, where the sign of the amount picks the direction;
- AND/OR/XOR of a 16-bit immediate into the middle word;
- two kinds of bit test.

A status set of carry, overflow, zero, negative and test-bit flags is kept next to the accumulators. The carry flag feeds back into the carry operations.

An operation is presented on `op_i` together with `valid_i`. The accumulator and flag outputs show its result after the next rising clock edge.

Top module: `acc_imm_alu`

## Requirements
- R1: After reset both accumulators and all five flags are zero.
- R2: Opcode 0 (load) writes the selected 32-bit source, sign-extended to 40 bits, into the selected accumulator. Source select bit 0 picks X (0) or Y (1). Flags are left unchanged.
- R3: Opcode 1 adds the low 8 bits of the immediate, sign-extended to 16 bits and placed at bits 31..16 with the upper bits sign-filled. Opcode 2 does the same with the full 16-bit immediate. In both cases the sum is written back truncated to 40 bits.
- R4: Opcodes 3 (short immediate) and 4 (long immediate) form accumulator minus the aligned immediate. They update carry, overflow, zero and negative and leave the accumulator unchanged.
- R5: Opcode 5 forms accumulator + sign-extended source + carry flag. Opcode 6 forms accumulator + inverted sign-extended source + carry flag. Both write back.
- R6: Opcode 7 replaces the accumulator with its inverse plus the carry flag, which is zero minus the accumulator minus the borrow.
- R7: Opcode 8 subtracts the magnitude of a 16-bit source half placed at bit 16 from the magnitude of the accumulator, and sets flags only. Select bit 1 picks the upper half (1) or the lower half (0). Carry is 1 when the accumulator magnitude is not smaller, and overflow is 0.
- R8: Opcodes 9 (logical) and 10 (arithmetic) shift by the signed low byte of the immediate. A negative amount shifts right by its magnitude and a non-negative amount shifts left. A magnitude of 40 or more gives zero, or the sign fill for an arithmetic right shift. Carry and overflow are forced to 0.
- R9: Opcodes 11, 12 and 13 apply AND, OR or XOR of the 16-bit immediate to bits 31..16 only. Carry and overflow become 0, and zero and negative follow the new accumulator.
- R10: Opcode 14 sets the test bit when middle word AND immediate is zero. Opcode 15 sets it when every immediate bit is set in the middle word. Neither opcode changes the accumulators or the other flags.
- R11: Zero means all 40 result bits are 0 and negative is bit 39. Carry is the carry out of bit 39, which is the inverted borrow for subtractions. Overflow marks signed 40-bit overflow.
- R12: With `valid_i` low, neither the accumulators nor the flags change.
- R13: `sel_b_i` = 1 selects B and 0 selects A. The unselected accumulator never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Execute the presented operation this cycle |
| op_i | input | 4 | Opcode |
| sel_b_i | input | 1 | Accumulator select (1 = B) |
| src_sel_i | input | 2 | Bit 0: Y instead of X; bit 1: upper source half for opcode 8 |
| imm_i | input | 16 | Immediate / shift amount (low byte) |
| x_i | input | 32 | Source X |
| y_i | input | 32 | Source Y |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| carry_o | output | 1 | Carry flag |
| ovf_o | output | 1 | Overflow flag |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |
| tbit_o | output | 1 | Test-bit flag |

## Verification
Every result, whether an accumulator value or a flag, is due exactly one rising edge after the edge that samples the operation, and nothing responds later than that. The bench applies each operation at a falling edge. It updates its behavioural model of the accumulators and flags at that point, then samples all outputs one nanosecond after the following rising edge. Idle cycles are checked the same way, so that one-cycle window is where any stray update would show up.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int ACC_W  = 40;
  localparam int SRC_W  = 32;
  localparam int IMM_W  = 16;
  localparam int SIMM_W = 8;
  localparam int ALIGN  = 16;
  localparam int N_ACC  = 2;

  typedef enum logic [3:0] {
    OP_LOAD  = 4'd0,
    OP_ADDS  = 4'd1,
    OP_ADDL  = 4'd2,
    OP_CMPS  = 4'd3,
    OP_CMPL  = 4'd4,
    OP_ADDC  = 4'd5,
    OP_SUBC  = 4'd6,
    OP_NEGC  = 4'd7,
    OP_MAG   = 4'd8,
    OP_LSH   = 4'd9,
    OP_ASH   = 4'd10,
    OP_ANDI  = 4'd11,
    OP_ORI   = 4'd12,
    OP_XORI  = 4'd13,
    OP_TSTZ  = 4'd14,
    OP_TSTA  = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic n;
    logic t;
  } flags_t;
endpackage

// File: rtl/acc_arith.sv
module acc_arith
  import acc_alu_pkg::*;
#(
  parameter int AW  = ACC_W,
  parameter int SW  = SRC_W,
  parameter int IW  = IMM_W,
  parameter int SIW = SIMM_W,
  parameter int AL  = ALIGN
) (
  input  alu_op_e         op_i,
  input  logic [AW-1:0]   acc_i,
  input  logic [SW-1:0]   src_i,
  input  logic [IW-1:0]   half_i,
  input  logic [IW-1:0]   imm_i,
  input  logic            cin_i,
  output logic [AW-1:0]   res_o,
  output logic            c_o,
  output logic            v_o
);
  localparam int TOP_W = AW - IW - AL;

  logic [IW-1:0] imm16;
  logic [AW-1:0] imm_al, half_al, src_ext;
  logic [AW-1:0] acc_mag, half_mag;
  logic [AW-1:0] opa, opb;
  logic          cin;
  logic [AW:0]   sum;

  always_comb begin
    imm16 = (op_i == OP_ADDS || op_i == OP_CMPS)
          ? {{(IW-SIW){imm_i[SIW-1]}}, imm_i[SIW-1:0]} : imm_i;
  end

  assign imm_al   = {{TOP_W{imm16[IW-1]}}, imm16, {AL{1'b0}}};
  assign half_al  = {{TOP_W{half_i[IW-1]}}, half_i, {AL{1'b0}}};
  assign src_ext  = {{(AW-SW){src_i[SW-1]}}, src_i};
  assign acc_mag  = acc_i[AW-1] ? (~acc_i + 1'b1) : acc_i;
  assign half_mag = half_al[AW-1] ? (~half_al + 1'b1) : half_al;

  // one shared adder; subtraction = invert operand, carry in
  always_comb begin
    opa = acc_i;
    opb = '0;
    cin = 1'b0;
    unique case (op_i)
      OP_ADDS, OP_ADDL: opb = imm_al;
      OP_CMPS, OP_CMPL: begin opb = ~imm_al;  cin = 1'b1;  end
      OP_ADDC:          begin opb = src_ext;  cin = cin_i; end
      OP_SUBC:          begin opb = ~src_ext; cin = cin_i; end
      OP_NEGC:          begin opa = '0; opb = ~acc_i; cin = cin_i; end
      OP_MAG:           begin opa = acc_mag; opb = ~half_mag; cin = 1'b1; end
      default:          ;
    endcase
  end

  assign sum   = {1'b0, opa} + {1'b0, opb} + {{AW{1'b0}}, cin};
  assign res_o = sum[AW-1:0];
  assign c_o   = sum[AW];
  assign v_o   = (op_i != OP_MAG) && (opa[AW-1] == opb[AW-1]) && (sum[AW-1] != opa[AW-1]);
endmodule

// File: rtl/acc_shift.sv
module acc_shift
  import acc_alu_pkg::*;
#(
  parameter int AW  = ACC_W,
  parameter int SIW = SIMM_W
) (
  input  logic [AW-1:0]  acc_i,
  input  logic [SIW-1:0] amt_i,
  input  logic           arith_i,
  output logic [AW-1:0]  res_o
);
  logic           right;
  logic [SIW-1:0] mag;
  logic           fill;

  assign right = amt_i[SIW-1];
  assign mag   = right ? (~amt_i + 1'b1) : amt_i;
  assign fill  = arith_i & acc_i[AW-1];

  always_comb begin
    if (int'(mag) >= AW)
      res_o = right ? {AW{fill}} : '0;
    else if (right)
      res_o = arith_i ? AW'($signed(acc_i) >>> mag) : (acc_i >> mag);
    else
      res_o = acc_i << mag;
  end
endmodule

// File: rtl/acc_logic.sv
module acc_logic
  import acc_alu_pkg::*;
#(
  parameter int AW = ACC_W,
  parameter int IW = IMM_W,
  parameter int AL = ALIGN
) (
  input  alu_op_e       op_i,
  input  logic [AW-1:0] acc_i,
  input  logic [IW-1:0] imm_i,
  output logic [AW-1:0] res_o,
  output logic          tbit_o
);
  logic [IW-1:0] mid, mid_nxt, hit;

  assign mid = acc_i[AL +: IW];
  assign hit = mid & imm_i;

  always_comb begin
    unique case (op_i)
      OP_ANDI: mid_nxt = mid & imm_i;
      OP_ORI:  mid_nxt = mid | imm_i;
      OP_XORI: mid_nxt = mid ^ imm_i;
      default: mid_nxt = mid;
    endcase
    res_o = acc_i;
    res_o[AL +: IW] = mid_nxt;
  end

  assign tbit_o = (op_i == OP_TSTA) ? (hit == imm_i) : (hit == '0);
endmodule

// File: rtl/acc_imm_alu.sv
module acc_imm_alu
  import acc_alu_pkg::*;
#(
  parameter int AW  = ACC_W,
  parameter int SW  = SRC_W,
  parameter int IW  = IMM_W,
  parameter int SIW = SIMM_W,
  parameter int AL  = ALIGN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic          sel_b_i,
  input  logic [1:0]    src_sel_i,
  input  logic [IW-1:0] imm_i,
  input  logic [SW-1:0] x_i,
  input  logic [SW-1:0] y_i,
  output logic [AW-1:0] acc_a_o,
  output logic [AW-1:0] acc_b_o,
  output logic          carry_o,
  output logic          ovf_o,
  output logic          zero_o,
  output logic          neg_o,
  output logic          tbit_o
);
  localparam int NA = N_ACC;

  alu_op_e       op;
  logic [AW-1:0] acc_q [NA];
  logic [AW-1:0] cur;
  logic [SW-1:0] src;
  logic [IW-1:0] half;
  flags_t        flags_q, flags_nxt;

  logic [AW-1:0] ar_res, sh_res, lg_res, acc_nxt, fval;
  logic          ar_c, ar_v, lg_t;
  logic          acc_wr, upd_cvzn;

  assign op   = alu_op_e'(op_i);
  assign cur  = acc_q[sel_b_i];
  assign src  = src_sel_i[0] ? y_i : x_i;
  assign half = src_sel_i[1] ? src[SW-1 -: IW] : src[IW-1:0];

  acc_arith #(.AW(AW), .SW(SW), .IW(IW), .SIW(SIW), .AL(AL)) u_arith (
    .op_i(op), .acc_i(cur), .src_i(src), .half_i(half), .imm_i(imm_i),
    .cin_i(flags_q.c), .res_o(ar_res), .c_o(ar_c), .v_o(ar_v)
  );

  acc_shift #(.AW(AW), .SIW(SIW)) u_shift (
    .acc_i(cur), .amt_i(imm_i[SIW-1:0]), .arith_i(op == OP_ASH), .res_o(sh_res)
  );

  acc_logic #(.AW(AW), .IW(IW), .AL(AL)) u_logic (
    .op_i(op), .acc_i(cur), .imm_i(imm_i), .res_o(lg_res), .tbit_o(lg_t)
  );

  always_comb begin
    acc_wr    = 1'b0;
    upd_cvzn  = 1'b0;
    acc_nxt   = cur;
    fval      = ar_res;
    flags_nxt = flags_q;
    unique case (op)
      OP_LOAD: begin
        acc_wr  = 1'b1;
        acc_nxt = {{(AW-SW){src[SW-1]}}, src};
      end
      OP_ADDS, OP_ADDL, OP_ADDC, OP_SUBC, OP_NEGC: begin
        acc_wr = 1'b1; upd_cvzn = 1'b1; acc_nxt = ar_res;
        flags_nxt.c = ar_c; flags_nxt.v = ar_v;
      end
      OP_CMPS, OP_CMPL, OP_MAG: begin
        upd_cvzn = 1'b1;
        flags_nxt.c = ar_c; flags_nxt.v = ar_v;
      end
      OP_LSH, OP_ASH: begin
        acc_wr = 1'b1; upd_cvzn = 1'b1; acc_nxt = sh_res; fval = sh_res;
        flags_nxt.c = 1'b0; flags_nxt.v = 1'b0;
      end
      OP_ANDI, OP_ORI, OP_XORI: begin
        acc_wr = 1'b1; upd_cvzn = 1'b1; acc_nxt = lg_res; fval = lg_res;
        flags_nxt.c = 1'b0; flags_nxt.v = 1'b0;
      end
      OP_TSTZ, OP_TSTA: flags_nxt.t = lg_t;
      default: ;
    endcase
    if (upd_cvzn) begin
      flags_nxt.z = (fval == '0);
      flags_nxt.n = fval[AW-1];
    end
  end

  for (genvar g = 0; g < NA; g++) begin : g_acc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        acc_q[g] <= '0;
      else if (valid_i && acc_wr && (sel_b_i == 1'(g)))
        acc_q[g] <= acc_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= '0;
    else if (valid_i) flags_q <= flags_nxt;
  end

  assign acc_a_o = acc_q[0];
  assign acc_b_o = acc_q[1];
  assign carry_o = flags_q.c;
  assign ovf_o   = flags_q.v;
  assign zero_o  = flags_q.z;
  assign neg_o   = flags_q.n;
  assign tbit_o  = flags_q.t;
endmodule

// File: rtl/acc_imm_alu_chk.sv
module acc_imm_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int AW = ACC_W,
  parameter int SW = SRC_W,
  parameter int IW = IMM_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [3:0]    op_i,
  input logic          sel_b_i,
  input logic [1:0]    src_sel_i,
  input logic [IW-1:0] imm_i,
  input logic [SW-1:0] x_i,
  input logic [SW-1:0] y_i,
  input logic [AW-1:0] acc_a_o,
  input logic [AW-1:0] acc_b_o,
  input logic          carry_o,
  input logic          ovf_o,
  input logic          zero_o,
  input logic          neg_o,
  input logic          tbit_o
);
  logic flag_only, is_shift, is_test, acc_flags;

  assign flag_only = (op_i == OP_CMPS) || (op_i == OP_CMPL) || (op_i == OP_MAG);
  assign is_shift  = (op_i == OP_LSH) || (op_i == OP_ASH);
  assign is_test   = (op_i == OP_TSTZ) || (op_i == OP_TSTA);
  assign acc_flags = !flag_only && !is_test && (op_i != OP_LOAD);

  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(acc_a_o) && $stable(acc_b_o) && $stable(carry_o) &&
                  $stable(ovf_o) && $stable(zero_o) && $stable(neg_o) && $stable(tbit_o)));

  // R4
  cmp_keeps_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && flag_only) |=> ($stable(acc_a_o) && $stable(acc_b_o) && $stable(tbit_o)));

  // R8
  shift_cv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_shift) |=> (!carry_o && !ovf_o));

  // R10
  test_only_tbit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_test) |=> ($stable(acc_a_o) && $stable(acc_b_o) && $stable(carry_o) &&
                              $stable(ovf_o) && $stable(zero_o) && $stable(neg_o)));

  // R11
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_flags) |=> (zero_o == (($past(sel_b_i) ? acc_b_o : acc_a_o) == '0)));

  // R11
  neg_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_flags) |=> (neg_o == ($past(sel_b_i) ? acc_b_o[AW-1] : acc_a_o[AW-1])));

  // R13
  other_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel_b_i) |=> $stable(acc_a_o));

  // R13
  other_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sel_b_i) |=> $stable(acc_b_o));

  // R2
  load_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_LOAD) |=> ($stable(carry_o) && $stable(ovf_o) && $stable(zero_o) &&
                                      $stable(neg_o) && $stable(tbit_o)));
endmodule

bind acc_imm_alu acc_imm_alu_chk u_chk (.*);

// File: tb/acc_imm_alu_test.sv
`timescale 1ns/1ps
module acc_imm_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic        sel_b = 1'b0;
  logic [1:0]  src_sel = '0;
  logic [15:0] imm = '0;
  logic [31:0] x = '0, y = '0;
  logic [39:0] acc_a, acc_b;
  logic        c_o, v_o, z_o, n_o, t_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // expected state
  logic [39:0] ma = '0, mb = '0;
  logic        mc = 0, mv = 0, mz = 0, mn = 0, mt = 0;

  always #4 clk = ~clk;

  acc_imm_alu uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .sel_b_i(sel_b),
    .src_sel_i(src_sel), .imm_i(imm), .x_i(x), .y_i(y),
    .acc_a_o(acc_a), .acc_b_o(acc_b), .carry_o(c_o), .ovf_o(v_o),
    .zero_o(z_o), .neg_o(n_o), .tbit_o(t_o)
  );

  function automatic longint sx40(input logic [39:0] v);
    return v[39] ? longint'({24'hFF_FFFF, v}) : longint'({24'h0, v});
  endfunction

  function automatic bit fits40(input longint e);
    return (e >= -(longint'(1) <<< 39)) && (e <= ((longint'(1) <<< 39) - 1));
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R2";
      4'd1, 4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9, 4'd10: return "R8";
      4'd11, 4'd12, 4'd13: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    check(req, "acc_a", acc_a, ma);
    check(req, "acc_b", acc_b, mb);
    check(req, "flags cvznt", {35'd0, c_o, v_o, z_o, n_o, t_o}, {35'd0, mc, mv, mz, mn, mt});
  endtask

  task automatic put(input bit sb, input logic [39:0] r);
    if (sb) mb = r; else ma = r;
  endtask

  task automatic setf(input logic c, input logic v, input logic [39:0] r);
    mc = c; mv = v; mz = (r == 40'd0); mn = r[39];
  endtask

  task automatic step(input bit vld, input logic [3:0] o, input bit sb, input logic [1:0] ss,
                      input logic [15:0] im, input logic [31:0] xv, input logic [31:0] yv,
                      input string req);
    logic [39:0] cur, res, s40;
    logic [40:0] u;
    logic [31:0] src;
    logic [15:0] half;
    longint d, s, e, dm, sm;
    int a;
    @(negedge clk);
    valid = vld; op = o; sel_b = sb; src_sel = ss; imm = im; x = xv; y = yv;
    cur  = sb ? mb : ma;
    d    = sx40(cur);
    src  = ss[0] ? yv : xv;
    half = ss[1] ? src[31:16] : src[15:0];
    if (vld) begin
      case (o)
        4'd0: put(sb, 40'(longint'($signed(src))));
        4'd1, 4'd2, 4'd3, 4'd4: begin
          s = ((o == 4'd1 || o == 4'd3) ? longint'($signed(im[7:0])) : longint'($signed(im))) * 65536;
          s40 = s[39:0];
          if (o <= 4'd2) begin
            e = d + s; res = e[39:0];
            u = {1'b0, cur} + {1'b0, s40};
            put(sb, res); setf(u[40], !fits40(e), res);
          end else begin
            e = d - s; res = e[39:0];
            setf(cur >= s40, !fits40(e), res);
          end
        end
        4'd5, 4'd6: begin
          s = longint'($signed(src)); s40 = s[39:0];
          if (o == 4'd5) begin
            e = d + s + longint'(mc); u = {1'b0, cur} + {1'b0, s40} + {40'd0, mc};
          end else begin
            e = d - s - 1 + longint'(mc); u = {1'b0, cur} + {1'b0, ~s40} + {40'd0, mc};
          end
          res = e[39:0]; put(sb, res); setf(u[40], !fits40(e), res);
        end
        4'd7: begin
          e = -d - 1 + longint'(mc); res = e[39:0];
          put(sb, res); setf((cur == 40'd0) && mc, !fits40(e), res);
        end
        4'd8: begin
          s = longint'($signed(half)) * 65536;
          dm = (d < 0) ? -d : d; sm = (s < 0) ? -s : s;
          e = dm - sm; res = e[39:0];
          setf(dm >= sm, 1'b0, res);
        end
        4'd9, 4'd10: begin
          a = int'($signed(im[7:0])); res = cur;
          if (a < 0) for (int k = 0; k < -a; k++) res = (o == 4'd10) ? {res[39], res[39:1]} : {1'b0, res[39:1]};
          else       for (int k = 0; k < a; k++)  res = {res[38:0], 1'b0};
          put(sb, res); setf(1'b0, 1'b0, res);
        end
        4'd11, 4'd12, 4'd13: begin
          res = cur;
          res[31:16] = (o == 4'd11) ? (cur[31:16] & im) : (o == 4'd12) ? (cur[31:16] | im) : (cur[31:16] ^ im);
          put(sb, res); setf(1'b0, 1'b0, res);
        end
        default: mt = (o == 4'd14) ? ((cur[31:16] & im) == 16'd0) : ((cur[31:16] & im) == im);
      endcase
    end
    @(posedge clk);
    #1;
    compare(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1;
    compare("R1");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    compare("R1");

    // R2 loads
    step(1, 4'd0, 0, 2'b00, 16'h0, 32'h0001_2345, 32'h0, "R2");
    step(1, 4'd0, 1, 2'b01, 16'h0, 32'h0, 32'h8000_0000, "R2");
    // R3 adds
    step(1, 4'd1, 0, 2'b00, 16'hAAFF, 32'h0, 32'h0, "R3");
    step(1, 4'd2, 1, 2'b00, 16'h7FFF, 32'h0, 32'h0, "R3");
    step(1, 4'd2, 1, 2'b00, 16'h8001, 32'h0, 32'h0, "R3");
    // R4 compares
    step(1, 4'd3, 0, 2'b00, 16'h0001, 32'h0, 32'h0, "R4");
    step(1, 4'd4, 1, 2'b00, 16'hFFFF, 32'h0, 32'h0, "R4");
    // R11 signed overflow at bit 39
    step(1, 4'd0, 0, 2'b00, 16'h0, 32'h7FFF_FFFF, 32'h0, "R11");
    step(1, 4'd10, 0, 2'b00, 16'h0008, 32'h0, 32'h0, "R11");
    step(1, 4'd2, 0, 2'b00, 16'h0001, 32'h0, 32'h0, "R11");
    step(1, 4'd2, 0, 2'b00, 16'h8000, 32'h0, 32'h0, "R11");
    // R11 carry out and zero
    step(1, 4'd0, 1, 2'b00, 16'h0, 32'hFFFF_0000, 32'h0, "R11");
    step(1, 4'd2, 1, 2'b00, 16'h0001, 32'h0, 32'h0, "R11");
    // R5 carry chain
    step(1, 4'd5, 1, 2'b01, 16'h0, 32'h0, 32'hFFFF_FFFF, "R5");
    step(1, 4'd6, 0, 2'b00, 16'h0, 32'h1234_0000, 32'h0, "R5");
    step(1, 4'd6, 0, 2'b01, 16'h0, 32'h0, 32'h8000_0000, "R5");
    step(1, 4'd5, 0, 2'b00, 16'h0, 32'h0000_0001, 32'h0, "R5");
    // R6 negate
    step(1, 4'd7, 0, 2'b00, 16'h0, 32'h0, 32'h0, "R6");
    step(1, 4'd0, 1, 2'b00, 16'h0, 32'h0, 32'h0, "R6");
    step(1, 4'd3, 1, 2'b00, 16'h0000, 32'h0, 32'h0, "R6");
    step(1, 4'd7, 1, 2'b00, 16'h0, 32'h0, 32'h0, "R6");
    // R7 magnitude compare
    step(1, 4'd0, 0, 2'b00, 16'h0, 32'hFFF0_0000, 32'h0, "R7");
    step(1, 4'd8, 0, 2'b10, 16'h0, 32'h0010_0000, 32'h0, "R7");
    step(1, 4'd8, 0, 2'b01, 16'h0, 32'h0, 32'h0000_8000, "R7");
    // R8 shifts incl. direction and saturation
    step(1, 4'd0, 0, 2'b00, 16'h0, 32'h8123_4567, 32'h0, "R8");
    step(1, 4'd10, 0, 2'b00, 16'h00FC, 32'h0, 32'h0, "R8");
    step(1, 4'd9, 0, 2'b00, 16'h00FC, 32'h0, 32'h0, "R8");
    step(1, 4'd9, 0, 2'b00, 16'h0005, 32'h0, 32'h0, "R8");
    step(1, 4'd10, 0, 2'b00, 16'h00D8, 32'h0, 32'h0, "R8");
    step(1, 4'd0, 0, 2'b00, 16'h0, 32'h8000_0001, 32'h0, "R8");
    step(1, 4'd10, 0, 2'b00, 16'h0080, 32'h0, 32'h0, "R8");
    step(1, 4'd0, 0, 2'b00, 16'h0, 32'h8000_0001, 32'h0, "R8");
    step(1, 4'd9, 0, 2'b00, 16'h00D9, 32'h0, 32'h0, "R8");
    step(1, 4'd0, 0, 2'b00, 16'h0, 32'h0000_0003, 32'h0, "R8");
    step(1, 4'd9, 0, 2'b00, 16'h0027, 32'h0, 32'h0, "R8");
    // R9 middle-word logic
    step(1, 4'd0, 1, 2'b00, 16'h0, 32'hF0F0_1234, 32'h0, "R9");
    step(1, 4'd11, 1, 2'b00, 16'h0FF0, 32'h0, 32'h0, "R9");
    step(1, 4'd12, 1, 2'b00, 16'hF000, 32'h0, 32'h0, "R9");
    step(1, 4'd13, 1, 2'b00, 16'hFFFF, 32'h0, 32'h0, "R9");
    // R10 bit tests
    step(1, 4'd14, 1, 2'b00, 16'h0F00, 32'h0, 32'h0, "R10");
    step(1, 4'd14, 1, 2'b00, 16'h000F, 32'h0, 32'h0, "R10");
    step(1, 4'd15, 1, 2'b00, 16'h000F, 32'h0, 32'h0, "R10");
    step(1, 4'd15, 1, 2'b00, 16'h00FF, 32'h0, 32'h0, "R10");
    // R12 idle cycles with live inputs
    step(0, 4'd0, 0, 2'b01, 16'hFFFF, 32'hDEAD_BEEF, 32'hCAFE_F00D, "R12");
    step(0, 4'd7, 1, 2'b00, 16'h1234, 32'h0, 32'h0, "R12");
    // R13 mixed traffic, random ops on both accumulators
    for (int i = 0; i < 400; i++) begin
      logic [3:0] ro;
      logic [15:0] ri;
      logic [31:0] rx;
      seed = seed * 32'd1664525 + 32'd1013904223;
      ro = seed[27:24];
      ri = seed[15:0];
      rx = seed ^ {seed[15:0], seed[31:16]};
      seed = seed * 32'd1664525 + 32'd1013904223;
      step(seed[30:28] != 3'd0, ro, seed[20], seed[22:21], ri, rx, seed,
           (i % 4 == 0) ? "R13" : req_of(ro));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule